// File: doc/BRIEF.md
# Extended TSEG Size Query Register Slice

This block is a small slice of a host bridge's configuration space. It lets boot firmware learn how large an extended protected-memory region (TSEG) the platform offers, and then select that region size. The block holds a 16-bit query register, a 2-bit size-select code and a lock bit. A static parameter gives the extended size in megabytes. From these the block produces a registered byte count for the selected TSEG size and a flag that shows extended mode is active.

Firmware uses a write-then-read-back sequence. First it writes all ones (0xFFFF) to the query register. When the extended size is configured, the register at once holds that size in megabytes. If the size is configured as zero, the register keeps whatever was written, so firmware reading back 0xFFFF learns that no extended size exists. The sentinel write is needed because configuration contents survive a warm reboot. A value planted earlier by an operating system must never be taken as an answer.

The configuration port is a plain single-cycle strobe. It has no valid/ready handshake because the slice accepts every write in the cycle it is presented, so there is no back-pressure. Reads are combinational on a separate read address.

Top module: `tseg_cfg_slice`

## Requirements
- R1: The query register occupies byte offsets 0x50 (low byte) and 0x51 (high byte). A read of dword 0x50 returns it little-endian in bits [15:0], with bits [31:16] zero.
- R2: When the configured size is nonzero and a write leaves the query register at 0xFFFF, the register holds the configured size in MB from the next read on.
- R3: The sentinel check applies to every write whose enabled byte lanes touch offset 0x50 or 0x51, including a single-byte write. A write to dword 0x50 whose enables cover only lanes 2 and 3 leaves the query register unchanged.
- R4: After reset with a nonzero configured size, the query register reads the configured size.
- R5: With a configured size of zero, the query register is plain storage. It resets to 0, and a written 0xFFFF reads back as 0xFFFF.
- R6: Size code 00 gives a tseg_bytes value of 0x0010_0000, 01 gives 0x0020_0000 and 10 gives 0x0080_0000. Code 11 gives the configured size × 0x10_0000, which is 0 when the configured size is zero. tseg_ext is 1 exactly when the code is 11 and the configured size is nonzero.
- R7: The control byte is at offset 0x9E, which is byte lane 2 of dword 0x9C. Bits [1:0] hold the size code and bit 2 holds the lock. The byte reads back in rdata[23:16]. Both fields reset to 0.
- R8: Once the lock bit is 1, writes to the control byte are ignored until reset, so both code and lock keep their values. The query register stays writable while the lock is set.
- R9: tseg_bytes and tseg_ext are registered. They reset to 0x0010_0000 and 0. After a write accepted at clock edge N, they change at edge N+1.
- R10: In a partial write to the query register, the byte whose enable is low keeps its previous value.
- R11: A configured extended size above 4095 is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one write per cycle |
| cfg_addr | input | 8 | Write byte address; the low two bits are ignored (dword select) |
| cfg_be | input | 4 | Write byte enables, one per lane |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_raddr | input | 8 | Read byte address (dword select) |
| cfg_rdata | output | 32 | Combinational read data for the addressed dword |
| tseg_bytes | output | 32 | Selected TSEG size in bytes, registered |
| tseg_ext | output | 1 | Extended size selected and available, registered |

## Verification
The hardest situation to reach is a sentinel completed by a single-byte write. The high byte must already hold 0xFF from an earlier lone write to offset 0x51, and then a write to offset 0x50 alone supplies the last 0xFF. The bench builds this in two partial writes and also shows that a write confined to the upper lanes of the same dword never triggers the check. The lock is exercised by arming it together with a code change, trying to overwrite it, and confirming the frozen size at the output while the query handshake still works. A second instance with a zero configured size runs the same writes, showing plain-storage behaviour and a zero reserved-code size side by side.

// File: rtl/tseg_pkg.sv
package tseg_pkg;
  localparam int unsigned MB_SHIFT     = 20;
  localparam int unsigned EXT_MB_LIMIT = 4095;
  localparam int unsigned CODE_LSB     = 0;
  localparam int unsigned LOCK_BIT     = 2;
  localparam logic [15:0] QRY_SENTINEL = 16'hFFFF;

  typedef enum logic [1:0] {
    SZ_1M  = 2'b00,
    SZ_2M  = 2'b01,
    SZ_8M  = 2'b10,
    SZ_EXT = 2'b11
  } tseg_code_e;

  function automatic logic [31:0] code_to_bytes(input tseg_code_e c, input logic [11:0] ext_mb);
    case (c)
      SZ_1M:   return 32'h0010_0000;
      SZ_2M:   return 32'h0020_0000;
      SZ_8M:   return 32'h0080_0000;
      default: return {ext_mb, 20'h0_0000};
    endcase
  endfunction
endpackage

// File: rtl/tseg_field_tap.sv
module tseg_field_tap #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [7:0]  OFS    = 8'h50,
  parameter int unsigned NBYTES = 2
) (
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W/8-1:0]   be,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NBYTES-1:0]     hit,
  output logic [NBYTES*8-1:0]   bytes_o
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LANES - 1);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] BADDR = ADDR_W'(OFS) + ADDR_W'(i);
    localparam int unsigned LANE = int'(BADDR & LMASK);
    assign hit[i] = we && ((addr & ~LMASK) == (BADDR & ~LMASK)) && be[LANE];
    assign bytes_o[i*8 +: 8] = wdata[LANE*8 +: 8];
  end

  logic unused_tap;
  assign unused_tap = ^{wdata, be, addr};
endmodule

// File: rtl/tseg_query_reg.sv
module tseg_query_reg #(
  parameter int unsigned EXT_MB = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  hit,
  input  logic [15:0] wbytes,
  output logic [15:0] q
);
  import tseg_pkg::*;
  localparam logic [15:0] EXT16   = 16'(EXT_MB);
  localparam logic [15:0] RST_VAL = (EXT_MB != 0) ? EXT16 : 16'h0000;

  logic [15:0] merged, nxt;

  always_comb begin
    for (int i = 0; i < 2; i++)
      merged[i*8 +: 8] = hit[i] ? wbytes[i*8 +: 8] : q[i*8 +: 8];
    nxt = ((EXT_MB != 0) && (merged == QRY_SENTINEL)) ? EXT16 : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (|hit)  q <= nxt;
  end

  if (EXT_MB != 0) begin : g_ext_chk
    // R2
    sentinel_resolved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q != QRY_SENTINEL);
  end

  // R3
  untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> $stable(q));

  // R10
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 2'b01 && {q[15:8], wbytes[7:0]} != QRY_SENTINEL) |=> $stable(q[15:8]));
endmodule

// File: rtl/tseg_sel_reg.sv
module tseg_sel_reg (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit,
  input  logic [7:0]            wbyte,
  output tseg_pkg::tseg_code_e  code,
  output logic                  lock
);
  import tseg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= SZ_1M;
      lock <= 1'b0;
    end else if (hit && !lock) begin
      code <= tseg_code_e'(wbyte[CODE_LSB +: 2]);
      lock <= wbyte[LOCK_BIT];
    end
  end

  // R8
  locked_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(code) && lock));
endmodule

// File: rtl/tseg_size_dec.sv
module tseg_size_dec #(
  parameter int unsigned EXT_MB = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tseg_pkg::tseg_code_e  code,
  output logic [31:0]           bytes_o,
  output logic                  ext_o
);
  import tseg_pkg::*;
  localparam logic [11:0] EXT12 = 12'(EXT_MB);
  localparam logic [31:0] EXT_BYTES = {EXT12, 20'h0_0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_o <= 32'h0010_0000;
      ext_o   <= 1'b0;
    end else begin
      bytes_o <= code_to_bytes(code, EXT12);
      ext_o   <= (code == SZ_EXT) && (EXT_MB != 0);
    end
  end

  // R6
  ext_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_o |-> (bytes_o == EXT_BYTES));

  // R9
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(code) && $stable(bytes_o)) |=> $stable(bytes_o));
endmodule

// File: rtl/tseg_cfg_slice.sv
module tseg_cfg_slice #(
  parameter int unsigned EXT_MB   = 16,
  parameter logic [7:0]  QRY_OFS  = 8'h50,
  parameter logic [7:0]  CTRL_OFS = 8'h9E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic [7:0]  cfg_raddr,
  output logic [31:0] cfg_rdata,
  output logic [31:0] tseg_bytes,
  output logic        tseg_ext
);
  import tseg_pkg::*;
  localparam int unsigned LANES = 4;
  localparam logic [7:0]  LMASK = 8'(LANES - 1);

  // R11
  initial begin : ext_range_chk
    assert (EXT_MB <= EXT_MB_LIMIT)
      else $fatal(1, "extended size %0d MB exceeds limit", EXT_MB);
  end

  logic [1:0]  qry_hit;
  logic [15:0] qry_bytes;
  logic [0:0]  ctl_hit;
  logic [7:0]  ctl_byte;
  logic [15:0] qry_q;
  tseg_code_e  code;
  logic        lock;

  tseg_field_tap #(.ADDR_W(8), .DATA_W(32), .OFS(QRY_OFS), .NBYTES(2)) u_qry_tap (
    .we(cfg_we), .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
    .hit(qry_hit), .bytes_o(qry_bytes));

  tseg_field_tap #(.ADDR_W(8), .DATA_W(32), .OFS(CTRL_OFS), .NBYTES(1)) u_ctl_tap (
    .we(cfg_we), .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
    .hit(ctl_hit), .bytes_o(ctl_byte));

  tseg_query_reg #(.EXT_MB(EXT_MB)) u_qry (
    .clk(clk), .rst_n(rst_n), .hit(qry_hit), .wbytes(qry_bytes), .q(qry_q));

  tseg_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .hit(ctl_hit[0]), .wbyte(ctl_byte),
    .code(code), .lock(lock));

  tseg_size_dec #(.EXT_MB(EXT_MB)) u_dec (
    .clk(clk), .rst_n(rst_n), .code(code),
    .bytes_o(tseg_bytes), .ext_o(tseg_ext));

  logic [7:0] ctl_view;
  assign ctl_view = {5'b0, lock, code};

  always_comb begin
    logic [7:0] ba;
    cfg_rdata = '0;
    for (int b = 0; b < int'(LANES); b++) begin
      ba = (cfg_raddr & ~LMASK) | 8'(b);
      if (ba == QRY_OFS)              cfg_rdata[b*8 +: 8] = qry_q[7:0];
      else if (ba == QRY_OFS + 8'd1)  cfg_rdata[b*8 +: 8] = qry_q[15:8];
      else if (ba == CTRL_OFS)        cfg_rdata[b*8 +: 8] = ctl_view;
    end
  end
endmodule

// File: tb/test_tseg_cfg_slice.sv
module test_tseg_cfg_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  cfg_raddr = '0;
  logic [31:0] rdata, rdata_z, bytes, bytes_z;
  logic        ext, ext_z;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  tseg_cfg_slice i_tseg_cfg_slice (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(rdata),
    .tseg_bytes(bytes), .tseg_ext(ext));

  tseg_cfg_slice #(.EXT_MB(0)) i_tseg_cfg_slice_zero (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(rdata_z),
    .tseg_bytes(bytes_z), .tseg_ext(ext_z));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [7:0] a);
    cfg_raddr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    rd(8'h50);
    chk("R4 query after reset", rdata, 32'h0000_0010);
    chk("R5 zero-config reset", rdata_z, 32'h0);
    rd(8'h9C);
    chk("R7 control reset", rdata, 32'h0);
    chk("R9 bytes reset", bytes, 32'h0010_0000);
    chk("R9 ext reset", {31'b0, ext}, 32'h0);
  endtask

  task automatic t_query();
    wr(8'h50, 4'b0011, 32'h0000_FFFF);
    rd(8'h50);
    chk("R2 sentinel resolves", rdata, 32'h0000_0010);
    chk("R5 zero-config keeps FFFF", rdata_z, 32'h0000_FFFF);
    wr(8'h50, 4'b0011, 32'h0000_1234);
    rd(8'h50);
    chk("R1 plain value readback", rdata, 32'h0000_1234);
  endtask

  task automatic t_partial();
    wr(8'h50, 4'b0010, 32'h0000_AB00);
    rd(8'h50);
    chk("R10 low byte kept", rdata, 32'h0000_AB34);
    wr(8'h50, 4'b1100, 32'hFFFF_FFFF);
    rd(8'h50);
    chk("R3 upper lanes ignored", rdata, 32'h0000_AB34);
    wr(8'h51, 4'b0010, 32'h0000_FF00);
    rd(8'h50);
    chk("R10 high byte only", rdata, 32'h0000_FF34);
    wr(8'h50, 4'b0001, 32'h0000_00FF);
    rd(8'h50);
    chk("R3 single-byte sentinel", rdata, 32'h0000_0010);
    chk("R3 zero-config partial", rdata_z, 32'h0000_FFFF);
  endtask

  task automatic t_decode();
    logic [31:0] exp_b [4];
    exp_b[0] = 32'h0010_0000; exp_b[1] = 32'h0020_0000;
    exp_b[2] = 32'h0080_0000; exp_b[3] = 32'h0100_0000;
    for (int c = 1; c < 4; c++) begin
      wr(8'h9C, 4'b0100, 32'(c) << 16);
      chk("R9 bytes not yet changed", bytes, exp_b[c-1]);
      rd(8'h9C);
      chk("R7 code readback", rdata, 32'(c) << 16);
      @(negedge clk);
      chk("R6 decoded bytes", bytes, exp_b[c]);
      chk("R6 ext flag", {31'b0, ext}, (c == 3) ? 32'h1 : 32'h0);
    end
    chk("R6 zero-config reserved code", bytes_z, 32'h0);
    chk("R6 zero-config ext", {31'b0, ext_z}, 32'h0);
  endtask

  task automatic t_lock();
    wr(8'h9C, 4'b0100, 32'h0006_0000);
    @(negedge clk);
    rd(8'h9C);
    chk("R8 lock set", rdata, 32'h0006_0000);
    chk("R8 locked size", bytes, 32'h0080_0000);
    wr(8'h9C, 4'b0100, 32'h0001_0000);
    @(negedge clk);
    rd(8'h9C);
    chk("R8 write ignored", rdata, 32'h0006_0000);
    chk("R8 size frozen", bytes, 32'h0080_0000);
    wr(8'h50, 4'b0011, 32'h0000_0000);
    rd(8'h50);
    chk("R8 query writable", rdata, 32'h0);
    wr(8'h50, 4'b0011, 32'h0000_FFFF);
    rd(8'h50);
    chk("R8 query handshake", rdata, 32'h0000_0010);
    do_reset();
    wr(8'h9C, 4'b0100, 32'h0001_0000);
    @(negedge clk);
    rd(8'h9C);
    chk("R8 unlocked by reset", rdata, 32'h0001_0000);
    chk("R8 size after reset", bytes, 32'h0020_0000);
  endtask

  initial begin
    t_reset();
    t_query();
    t_partial();
    t_decode();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule